// File: doc/BRIEF.md
# Four-Channel Double-Buffered Output Code Loader

This block is the host-facing register logic in front of four 12-bit output converters. The host builds each 12-bit code in two byte writes. The first write goes to a low-byte register that all four channels share. The second write goes to the high-nibble address of the chosen channel. That second write joins the nibble with the shared low byte and places the result in the channel's pending buffer. The converter outputs do not move at that point.

A read of any of the four channel addresses applies the update. In that one clock edge, every channel that holds fresh pending data moves it to its active output. A channel with no new data since the last update keeps its output. The usual host sequence is therefore: low byte, high nibble, repeated for each channel that changes, then a single read to update them all together.

The host side is two independent request streams, one for writes and one for reads. Each uses a valid/ready pair. A request is accepted on a rising clock edge where valid and ready are both high. The block never applies back-pressure: both ready outputs are high whenever reset is released. So a write and a read can be accepted in the same cycle. The read returns no data; it only acts as the update strobe.

Top module: `dac_bank_loader`

## Requirements
- R1: While reset is asserted and after it is released, all four active output codes are 0 and no channel has pending new data, so an update read made right after reset leaves every output at 0.
- R2: A write accepted at address 1 stores its 8 data bits in the shared low-byte register. This write does not change any output.
- R3: A write accepted at address 4+k (k = 0..3) stores {data[3:0], shared low byte} as channel k's pending code. Data bits 7:4 are ignored. No output changes until an update. This holds for the boundary codes 0x000 and 0xFFF.
- R4: A read accepted at any address 4 to 7 copies pending codes to active outputs on that same clock edge, for all channels at once. The new values are visible in the following cycle.
- R5: On an update, a channel that received no high-nibble write since the previous update keeps its present output.
- R6: If a high-nibble write to channel k is accepted in the same cycle as an update read, channel k's output takes the previously pending code, if there was one. The new code stays pending and appears at the next update.
- R7: Reads at addresses other than 4 to 7 do not update outputs. Writes at addresses other than 1 and 4 to 7 change neither the outputs nor any stored value.
- R8: wr_ready and rd_ready are 1 in every cycle after reset is released, so no request waits.
- R9: The shared low byte persists after a high-nibble write. Several channels can be loaded from one low-byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with wr_valid |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with rd_valid |
| rd_addr | input | 4 | Read address; 4 to 7 trigger the update |
| dac_code | output | 48 | Active codes; channel k in bits [12k+11:12k] |

## Verification
The bench loads the channels in several patterns:
- one channel at a time, which separates update timing from the latching of a single value;
- several channels from one low byte, which exposes a low byte that fails to persist;
- an update with nothing pending, which shows that untouched channels hold;
- a write that collides with an update, which tells "write wins" apart from "write lost" and "write applied early";
- codes of all ones and all zeros, together with non-channel reads and writes, which catch wrong nibble placement and loose address decoding.

A long stretch of mixed random traffic is checked against a behavioural model on every clock.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  // Default geometry of the host register window
  localparam int unsigned BUS_AW    = 4;
  localparam int unsigned BUS_DW    = 8;
  localparam int unsigned CODE_BITS = 12;
  localparam int unsigned CHANNELS  = 4;
  localparam int unsigned LOW_ADDR  = 1;
  localparam int unsigned HIGH_BASE = 4;

  // Classification of one accepted write
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOW   = 2'd1,
    ACC_HIGH  = 2'd2,
    ACC_OTHER = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import dac_bank_pkg::*;
#(
  parameter int unsigned ADDR_W  = BUS_AW,
  parameter int unsigned NUM_CH  = CHANNELS,
  parameter int unsigned LO_ADDR = LOW_ADDR,
  parameter int unsigned HI_BASE = HIGH_BASE
) (
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic              upd
);

  localparam int unsigned HI_LAST = HI_BASE + NUM_CH - 1;

  acc_kind_e wr_kind;

  always_comb begin
    if (!wr_fire) begin
      wr_kind = ACC_NONE;
    end else if (int'(wr_addr) == int'(LO_ADDR)) begin
      wr_kind = ACC_LOW;
    end else if (int'(wr_addr) >= int'(HI_BASE) && int'(wr_addr) <= int'(HI_LAST)) begin
      wr_kind = ACC_HIGH;
    end else begin
      wr_kind = ACC_OTHER;
    end
  end

  assign lo_we = (wr_kind == ACC_LOW);

  // One strobe per channel nibble address
  for (genvar k = 0; k < int'(NUM_CH); k++) begin : g_hi
    assign hi_we[k] = (wr_kind == ACC_HIGH) && (int'(wr_addr) == int'(HI_BASE) + k);
  end

  assign upd = rd_fire && (int'(rd_addr) >= int'(HI_BASE)) && (int'(rd_addr) <= int'(HI_LAST));

endmodule

// File: rtl/dac_low_latch.sv
module dac_low_latch #(
  parameter int unsigned LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [LO_W-1:0] din,
  output logic [LO_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= din;
    end
  end

endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned LO_W   = 8,
  localparam int unsigned HI_W  = CODE_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HI_W-1:0]   nib,
  input  logic [LO_W-1:0]   low,
  input  logic              upd,
  output logic [CODE_W-1:0] active
);

  logic [CODE_W-1:0] pend;
  logic              fresh;

  // Pending buffer: filled by the channel's high-nibble write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (load) begin
      pend <= {nib, low};
    end
  end

  // New-data flag: a write in the update cycle wins and stays set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh <= 1'b0;
    end else if (load) begin
      fresh <= 1'b1;
    end else if (upd) begin
      fresh <= 1'b0;
    end
  end

  // Active code: takes the value pending before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (upd && fresh) begin
      active <= pend;
    end
  end

endmodule

// File: rtl/dac_bank_loader.sv
module dac_bank_loader
  import dac_bank_pkg::*;
#(
  parameter int unsigned ADDR_W  = BUS_AW,
  parameter int unsigned DATA_W  = BUS_DW,
  parameter int unsigned CODE_W  = CODE_BITS,
  parameter int unsigned NUM_CH  = CHANNELS,
  parameter int unsigned LO_ADDR = LOW_ADDR,
  parameter int unsigned HI_BASE = HIGH_BASE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_valid,
  output logic                     rd_ready,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NUM_CH*CODE_W-1:0] dac_code
);

  localparam int unsigned LO_W = DATA_W;
  localparam int unsigned HI_W = CODE_W - LO_W;

  logic              wr_fire;
  logic              rd_fire;
  logic              lo_we;
  logic [NUM_CH-1:0] hi_we;
  logic              upd;
  logic [LO_W-1:0]   low_q;

  // The loader accepts a request on every cycle out of reset
  assign wr_ready = rst_n;
  assign rd_ready = rst_n;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;

  dac_bus_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH),
    .LO_ADDR(LO_ADDR),
    .HI_BASE(HI_BASE)
  ) u_decode (
    .wr_fire(wr_fire),
    .wr_addr(wr_addr),
    .rd_fire(rd_fire),
    .rd_addr(rd_addr),
    .lo_we  (lo_we),
    .hi_we  (hi_we),
    .upd    (upd)
  );

  dac_low_latch #(
    .LO_W(LO_W)
  ) u_low (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (lo_we),
    .din  (wr_data),
    .q    (low_q)
  );

  for (genvar k = 0; k < int'(NUM_CH); k++) begin : g_ch
    dac_chan_slice #(
      .CODE_W(CODE_W),
      .LO_W  (LO_W)
    ) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hi_we[k]),
      .nib   (wr_data[HI_W-1:0]),
      .low   (low_q),
      .upd   (upd),
      .active(dac_code[k*CODE_W +: CODE_W])
    );
  end

endmodule

// File: rtl/dac_bank_loader_chk.sv
module dac_bank_loader_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned LO_ADDR = 1,
  parameter int unsigned HI_BASE = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_valid,
  input logic                     wr_ready,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic                     rd_valid,
  input logic                     rd_ready,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [NUM_CH*CODE_W-1:0] dac_code
);

  localparam int unsigned HI_W = CODE_W - DATA_W;

  logic rd_upd;
  logic wr_any;
  logic wr_lo;

  assign wr_any = wr_valid && wr_ready;
  assign wr_lo  = wr_any && (int'(wr_addr) == int'(LO_ADDR));
  assign rd_upd = rd_valid && rd_ready && (int'(rd_addr) >= int'(HI_BASE))
                  && (int'(rd_addr) < int'(HI_BASE + NUM_CH));

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_code == '0));

  // R7
  hold_without_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_upd |=> $stable(dac_code));

  for (genvar k = 0; k < int'(NUM_CH); k++) begin : g_ck
    logic wr_hi_k;
    assign wr_hi_k = wr_any && (int'(wr_addr) == int'(HI_BASE) + k);

    // R3
    load_then_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo ##1 wr_hi_k ##1 (rd_upd && !wr_any)
      |=> dac_code[k*CODE_W +: CODE_W] == {$past(wr_data[HI_W-1:0], 2), $past(wr_data, 3)});

    // R6
    collide_then_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_k && rd_upd) ##1 (rd_upd && !wr_any)
      |=> dac_code[k*CODE_W + DATA_W +: HI_W] == $past(wr_data[HI_W-1:0], 2));
  end

  // R8
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (wr_ready && rd_ready));

endmodule

bind dac_bank_loader dac_bank_loader_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CODE_W (CODE_W),
  .NUM_CH (NUM_CH),
  .LO_ADDR(LO_ADDR),
  .HI_BASE(HI_BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_valid(rd_valid),
  .rd_ready(rd_ready),
  .rd_addr (rd_addr),
  .dac_code(dac_code)
);

// File: tb/dac_bank_loader_test.sv
module dac_bank_loader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [3:0]  rd_addr = '0;
  logic [47:0] dac_code;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // Behavioural reference state
  int m_low;
  int m_pend[4];
  int m_act[4];
  bit m_new[4];

  always #2.5 clk = ~clk;

  dac_bank_loader uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .dac_code(dac_code)
  );

  task automatic model_reset();
    m_low = 0;
    for (int i = 0; i < 4; i++) begin
      m_pend[i] = 0; m_act[i] = 0; m_new[i] = 1'b0;
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    for (int i = 0; i < 4; i++) begin
      if (dac_code[i*12 +: 12] !== 12'(m_act[i])) begin
        errors++;
        $display("FAIL %s ch%0d: actual %03h expected %03h", tag, i,
                 dac_code[i*12 +: 12], m_act[i]);
      end
    end
    if (rst_n && (wr_ready !== 1'b1 || rd_ready !== 1'b1)) begin
      errors++;
      $display("FAIL R8 ready: actual %b%b expected 11", wr_ready, rd_ready);
    end
  endtask

  // One clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cycle(input bit wv, input int wa, input int wd,
                       input bit rv, input int ra, input string tag);
    bit upd;
    int ch;
    wr_valid = wv; wr_addr = 4'(wa); wr_data = 8'(wd);
    rd_valid = rv; rd_addr = 4'(ra);
    @(posedge clk);
    upd = rv && ra >= 4 && ra <= 7;
    if (upd) begin
      for (int i = 0; i < 4; i++) begin
        if (m_new[i]) m_act[i] = m_pend[i];
        m_new[i] = 1'b0;
      end
    end
    if (wv && wa == 1) m_low = wd & 8'hFF;
    if (wv && wa >= 4 && wa <= 7) begin
      ch = wa - 4;
      m_pend[ch] = ((wd & 4'hF) << 8) | m_low;
      m_new[ch]  = 1'b1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cycle(1'b0, 0, 0, 1'b0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");                       // outputs zero in reset
    rst_n = 1'b1;
    cycle(1'b0, 0, 0, 1'b1, 5, "R1");    // update straight after reset keeps zeros

    // R2: low byte stored, no output change
    cycle(1'b1, 1, 8'h34, 1'b0, 0, "R2");
    // R3: upper data bits ignored, nothing moves before update
    cycle(1'b1, 4, 8'hF2, 1'b0, 0, "R3");
    // R7: non-channel read and stray write have no effect
    cycle(1'b0, 0, 0, 1'b1, 2, "R7");
    cycle(1'b1, 9, 8'hFF, 1'b1, 3, "R7");
    // R9: reuse low byte for a second channel
    cycle(1'b1, 5, 8'h05, 1'b0, 0, "R9");
    // R4: one read updates both
    cycle(1'b0, 0, 0, 1'b1, 6, "R4");
    idle("R4");

    // R5: only the written channel moves
    cycle(1'b1, 1, 8'hAB, 1'b0, 0, "R2");
    cycle(1'b1, 7, 8'h0C, 1'b0, 0, "R3");
    cycle(1'b0, 0, 0, 1'b1, 4, "R5");
    cycle(1'b0, 0, 0, 1'b1, 7, "R5");   // nothing pending

    // R6: collision of write and update
    cycle(1'b1, 1, 8'h11, 1'b0, 0, "R6");
    cycle(1'b1, 6, 8'h07, 1'b0, 0, "R6");
    cycle(1'b1, 6, 8'h09, 1'b1, 7, "R6");
    cycle(1'b0, 0, 0, 1'b1, 5, "R6");

    // R3 boundaries: all ones then all zeros
    cycle(1'b1, 1, 8'hFF, 1'b0, 0, "R3");
    for (int c = 0; c < 4; c++) cycle(1'b1, 4 + c, 8'hFF, 1'b0, 0, "R3");
    cycle(1'b0, 0, 0, 1'b1, 4, "R3");
    cycle(1'b1, 1, 8'h00, 1'b0, 0, "R3");
    cycle(1'b1, 4, 8'h00, 1'b0, 0, "R3");
    cycle(1'b0, 0, 0, 1'b1, 4, "R3");
    cycle(1'b0, 0, 0, 1'b1, 5, "R5");   // back-to-back update

    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      cycle(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule